// File: doc/BRIEF.md
# Test ROM Signature Compressor

This block checks the address decoding of an embedded nonvolatile memory array without a single programming cycle. The array has extra read-only test rows and columns around its core, and those cells are reached through the normal row and column decoders. The block drives the array's 4-bit mode selector and sweeps the addresses so that every test ROM cell is read once. It folds each returned byte into an 8-bit multiple-input signature register (MISR). A wrong decode changes the data stream, and so the signature.

When the sweep is over, the signature is shifted out serially for an external tester to compare. As a build option, it is also compared on chip against a constant, and the pass/fail result is meant to be ANDed into the self-test's overall good flag. Read data comes back with a fixed one-clock latency and carries no valid/ready handshake. The serial output has no back-pressure: its consumer has to take one bit on every clock in which the strobe is high, because the block never holds a bit.

Top module: `rom_sig_compressor`

## Requirements
- R1: During and right after reset, mode_o is 0, both address outputs are 0, and sig_out_o, sig_valid_o, finished_o and rom_ok_o are all low. An asynchronous reset part-way through a sweep returns the block to this idle state.
- R2: The first clock after start is sampled while idle begins the row phase. mode_o is 6 in this phase. The ROM row index k runs from 0 to 3 and is driven on row_addr_o with zero upper bits. For each k, col_addr_o counts from 0 to 2^COL_AW-1, one address per clock, with the column changing fastest. The phase lasts 4*2^COL_AW clocks.
- R3: The column phase follows directly, with no gap. mode_o is 7 in this phase. The ROM column index k runs from 0 to 3 and is driven on col_addr_o. For each k, row_addr_o counts from 0 to 2^ROW_AW-1. The phase lasts 4*2^ROW_AW clocks.
- R4: The MISR is cleared to 0 when a run starts. Each address's read byte arrives on rd_data_i one clock after that address is driven, and it is absorbed as s' = {s[6:0],0} XOR (s[7] ? 8'h1D : 0) XOR d, which is the polynomial x^8+x^4+x^3+x^2+1.
- R5: After the last byte has been absorbed, the signature is shown on sig_out_o MSB first, one bit per clock, for 8 consecutive clocks with sig_valid_o high. sig_out_o is 0 whenever sig_valid_o is low, and sig_valid_o is never high while mode_o is nonzero.
- R6: finished_o is high for exactly one clock, the clock right after the last serial bit.
- R7: With COMPARE_EN=1, rom_ok_o becomes (signature == EXPECTED_SIG) in the finished_o clock and holds that value until the next start. It is low from start until then. With COMPARE_EN=0, rom_ok_o is 1 at finish.
- R8: A start pulse that arrives while a run is in progress is ignored: the address sequence, the signature and the timing are all unchanged.
- R9: Outside the two sweep phases, mode_o is 0 (normal read) and both address outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| mode_o | output | 4 | Array mode selector: 6 = ROM rows, 7 = ROM columns, 0 = idle |
| row_addr_o | output | ROW_AW | Row address, or the ROM row index in mode 6 |
| col_addr_o | output | COL_AW | Column address, or the ROM column index in mode 7 |
| rd_data_i | input | 8 | Array read byte, one clock after its address |
| sig_out_o | output | 1 | Serial signature, MSB first |
| sig_valid_o | output | 1 | Marks the clocks that carry sig_out_o |
| finished_o | output | 1 | One-clock end-of-run pulse |
| rom_ok_o | output | 1 | Internal compare result, or constant 1 when compare is off |

## Verification
Because of the one-clock read latency, the byte for the last mode-6 address is absorbed in the same clock that the first mode-7 address is driven. The same overlap occurs at the end of the sweep: the final byte is absorbed while the mode has already dropped to 0. The bench models the array as a register fed by a seeded function of mode and address, so a lost, duplicated or misaligned byte at either seam changes the serial signature. That signature is compared against one the bench folds itself in the required order. Several ROM seeds are used, some runs include an extra start pulse mid-sweep, and a reset is applied during a sweep.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam logic [3:0] MODE_IDLE = 4'd0;
  localparam logic [3:0] MODE_ROWS = 4'd6;
  localparam logic [3:0] MODE_COLS = 4'd7;
  localparam int SIG_W = 8;
  localparam logic [SIG_W-1:0] SIG_POLY = 8'h1D;

  typedef enum logic [2:0] {
    S_IDLE, S_SWEEP, S_DRAIN, S_SHIFT, S_DONE
  } rsc_state_e;

  function automatic logic [SIG_W-1:0] sig_fold(input logic [SIG_W-1:0] s,
                                                input logic [SIG_W-1:0] d);
    return {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? SIG_POLY : '0) ^ d;
  endfunction
endpackage

// File: rtl/rsc_sweep.sv
module rsc_sweep
  import rsc_pkg::*;
#(
  parameter int ROW_AW = 8,
  parameter int COL_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [3:0]        mode_o,
  output logic [ROW_AW-1:0] row_o,
  output logic [COL_AW-1:0] col_o,
  output logic              clr_o,
  output logic              cap_o,
  output logic              shift_o,
  output logic [2:0]        bit_o,
  output logic              done_o
);
  localparam int CNT_W = (ROW_AW > COL_AW) ? ROW_AW : COL_AW;

  rsc_state_e       state;
  logic             phase;
  logic [1:0]       outer;
  logic [CNT_W-1:0] inner;
  logic             inner_last;
  logic             cap_q;
  logic [2:0]       bit_q;

  always_comb begin
    inner_last = phase ? (inner[ROW_AW-1:0] == {ROW_AW{1'b1}})
                       : (inner[COL_AW-1:0] == {COL_AW{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      phase <= 1'b0;
      outer <= '0;
      inner <= '0;
      cap_q <= 1'b0;
      bit_q <= '0;
    end else begin
      cap_q <= (state == S_SWEEP);
      case (state)
        S_IDLE: if (start) begin
          state <= S_SWEEP;
          phase <= 1'b0;
          outer <= '0;
          inner <= '0;
        end
        S_SWEEP: begin
          if (inner_last) begin
            inner <= '0;
            outer <= outer + 2'd1;
            if (outer == 2'd3) begin
              if (phase) state <= S_DRAIN;
              else       phase <= 1'b1;
            end
          end else begin
            inner <= inner + 1'b1;
          end
        end
        S_DRAIN: begin
          state <= S_SHIFT;
          bit_q <= '0;
        end
        S_SHIFT: begin
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mode_o = MODE_IDLE;
    row_o  = '0;
    col_o  = '0;
    if (state == S_SWEEP) begin
      if (!phase) begin
        mode_o = MODE_ROWS;
        row_o  = ROW_AW'(outer);
        col_o  = inner[COL_AW-1:0];
      end else begin
        mode_o = MODE_COLS;
        row_o  = inner[ROW_AW-1:0];
        col_o  = COL_AW'(outer);
      end
    end
  end

  assign clr_o   = (state == S_IDLE) && start;
  assign cap_o   = cap_q;
  assign shift_o = (state == S_SHIFT);
  assign bit_o   = bit_q;
  assign done_o  = (state == S_DONE);

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_ROWS && $past(mode_o) == MODE_ROWS && col_o != '0)
      |-> col_o == COL_AW'($past(col_o) + 1'b1));

  // R6
  finished_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/rsc_misr.sv
module rsc_misr
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap,
  input  logic [SIG_W-1:0] data,
  output logic [SIG_W-1:0] sig_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sig_o <= '0;
    else if (clr) sig_o <= '0;
    else if (cap) sig_o <= sig_fold(sig_o, data);
  end

  // R4
  misr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sig_o == '0);
endmodule

// File: rtl/rsc_report.sv
module rsc_report
  import rsc_pkg::*;
#(
  parameter bit               COMPARE_EN   = 1'b1,
  parameter logic [SIG_W-1:0] EXPECTED_SIG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic [2:0]       bit_idx,
  input  logic [SIG_W-1:0] sig_i,
  output logic             sig_out_o,
  output logic             sig_valid_o,
  output logic             ok_o
);
  logic cmp_ok;

  generate
    if (COMPARE_EN) begin : g_cmp
      assign cmp_ok = (sig_i == EXPECTED_SIG);
    end else begin : g_nocmp
      assign cmp_ok = 1'b1;
    end
  endgenerate

  assign sig_valid_o = shift;
  assign sig_out_o   = shift & sig_i[3'd7 - bit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ok_o <= 1'b0;
    else if (clr)                      ok_o <= 1'b0;
    else if (shift && bit_idx == 3'd7) ok_o <= cmp_ok;
  end

  // R5
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && $past(shift)) |-> $stable(sig_i));

  // R7
  ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ok_o);
endmodule

// File: rtl/rom_sig_compressor.sv
module rom_sig_compressor
  import rsc_pkg::*;
#(
  parameter int               ROW_AW       = 8,
  parameter int               COL_AW       = 8,
  parameter bit               COMPARE_EN   = 1'b1,
  parameter logic [SIG_W-1:0] EXPECTED_SIG = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [3:0]        mode_o,
  output logic [ROW_AW-1:0] row_addr_o,
  output logic [COL_AW-1:0] col_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              sig_out_o,
  output logic              sig_valid_o,
  output logic              finished_o,
  output logic              rom_ok_o
);
  logic             clr, cap, shift;
  logic [2:0]       bit_idx;
  logic [SIG_W-1:0] sig;

  rsc_sweep #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_sweep (
    .clk, .rst_n, .start,
    .mode_o, .row_o(row_addr_o), .col_o(col_addr_o),
    .clr_o(clr), .cap_o(cap), .shift_o(shift), .bit_o(bit_idx),
    .done_o(finished_o)
  );

  rsc_misr u_misr (
    .clk, .rst_n, .clr, .cap, .data(rd_data_i), .sig_o(sig)
  );

  rsc_report #(.COMPARE_EN(COMPARE_EN), .EXPECTED_SIG(EXPECTED_SIG)) u_report (
    .clk, .rst_n, .clr, .shift, .bit_idx, .sig_i(sig),
    .sig_out_o, .sig_valid_o, .ok_o(rom_ok_o)
  );

  // R5
  valid_idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid_o |-> mode_o == MODE_IDLE);
endmodule

// File: tb/rom_sig_compressor_tb.sv
module rom_sig_compressor_tb_top;
  localparam int ROW_AW = 5;
  localparam int COL_AW = 4;
  localparam int NR = 1 << ROW_AW;
  localparam int NC = 1 << COL_AW;

  // array model: byte for (mode,row,col) under a seed; 0 outside ROM modes
  function automatic logic [7:0] rom_byte(input logic [3:0] m, input int r,
                                          input int c, input logic [7:0] seed);
    logic [7:0] v;
    v = 8'(r * 29) ^ 8'(c * 7) ^ seed;
    if (m == 4'd7) return v ^ 8'h5A;
    if (m == 4'd6) return v;
    return 8'h00;
  endfunction

  function automatic logic [7:0] fold(input logic [7:0] s, input logic [7:0] d);
    logic [7:0] n;
    n = s << 1;
    if (s[7]) n = n ^ 8'b0001_1101;
    return n ^ d;
  endfunction

  function automatic logic [7:0] ref_sig(input logic [7:0] seed);
    logic [7:0] s;
    s = 8'h00;
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < NC; c++) s = fold(s, rom_byte(4'd6, k, c, seed));
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < NR; r++) s = fold(s, rom_byte(4'd7, r, k, seed));
    return s;
  endfunction

  localparam logic [7:0] GOLD = ref_sig(8'h00);

  // vector: [9:2] seed, [1] extra start mid-run, [0] expected rom_ok of dut_i
  localparam logic [9:0] VEC [4] = '{
    {8'h00, 1'b0, 1'b1},
    {8'h3C, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] seed = 8'h00;
  logic [3:0] mode;
  logic [ROW_AW-1:0] row;
  logic [COL_AW-1:0] col;
  logic [7:0] rd_q;
  logic so, sv, fin, ok;
  logic so_b, sv_b, fin_b, ok_b;
  logic so_n, sv_n, fin_n, ok_n;
  logic [3:0] mode_b, mode_n;
  logic [ROW_AW-1:0] row_b, row_n;
  logic [COL_AW-1:0] col_b, col_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) rd_q <= rom_byte(mode, int'(row), int'(col), seed);

  rom_sig_compressor #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .COMPARE_EN(1'b1),
    .EXPECTED_SIG(GOLD)) dut_i (
    .clk, .rst_n, .start, .mode_o(mode), .row_addr_o(row), .col_addr_o(col),
    .rd_data_i(rd_q), .sig_out_o(so), .sig_valid_o(sv), .finished_o(fin),
    .rom_ok_o(ok));

  rom_sig_compressor #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .COMPARE_EN(1'b1),
    .EXPECTED_SIG(~GOLD)) dut_mis (
    .clk, .rst_n, .start, .mode_o(mode_b), .row_addr_o(row_b), .col_addr_o(col_b),
    .rd_data_i(rd_q), .sig_out_o(so_b), .sig_valid_o(sv_b), .finished_o(fin_b),
    .rom_ok_o(ok_b));

  rom_sig_compressor #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .COMPARE_EN(1'b0),
    .EXPECTED_SIG(GOLD)) dut_nocmp (
    .clk, .rst_n, .start, .mode_o(mode_n), .row_addr_o(row_n), .col_addr_o(col_n),
    .rd_data_i(rd_q), .sig_out_o(so_n), .sig_valid_o(sv_n), .finished_o(fin_n),
    .rom_ok_o(ok_n));

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(mode == 4'd0 && row == '0 && col == '0, req, int'(mode), 0);
    check(!so && !sv && !fin && !ok, req, int'({so, sv, fin, ok}), 0);
  endtask

  task automatic run(input logic [7:0] sd, input bit poke, input bit exp_ok);
    int n6 = 0, n7 = 0, nv = 0, nf = 0, last_v = -1, fin_k = -1;
    int addr_err = 0, idle_err = 0, run_ok_err = 0;
    bit done = 1'b0;
    logic [7:0] bits = 8'h00;
    logic ok_at, okb_at, okn_at;
    seed = sd;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 4000 && !done; k++) begin
      if (k > 0) @(negedge clk);
      if (poke) start = (k == 20);
      if (mode == 4'd6) begin
        if (n7 != 0 || int'(row) != n6 / NC || int'(col) != n6 % NC) addr_err++;
        n6++;
      end else if (mode == 4'd7) begin
        if (int'(row) != n7 % NR || int'(col) != n7 / NR) addr_err++;
        n7++;
      end else if (mode != 4'd0 || row != '0 || col != '0) idle_err++;
      if (sv) begin
        bits = {bits[6:0], so};
        nv++;
        last_v = k;
        if (mode != 4'd0) idle_err++;
      end else if (so) idle_err++;
      if (fin) begin
        nf++;
        fin_k = k;
        ok_at = ok; okb_at = ok_b; okn_at = ok_n;
        done = 1'b1;
      end else if (ok) run_ok_err++;
    end
    check(n6 == 4 * NC && addr_err == 0, "R2 row-phase sweep", n6, 4 * NC);
    check(n7 == 4 * NR && addr_err == 0, "R3 column-phase sweep", n7, 4 * NR);
    check(bits == ref_sig(sd), poke ? "R4/R8 signature" : "R4 signature",
          int'(bits), int'(ref_sig(sd)));
    check(nv == 8, "R5 serial bit count", nv, 8);
    check(nf == 1 && fin_k == last_v + 1, "R6 finished timing", fin_k, last_v + 1);
    check(ok_at == exp_ok && run_ok_err == 0, "R7 rom_ok compare", int'(ok_at), int'(exp_ok));
    check(okb_at == 1'b0 && okn_at == 1'b1, "R7 mismatch/disabled", int'({okb_at, okn_at}), 1);
    check(idle_err == 0, "R9 idle outputs", idle_err, 0);
    @(negedge clk);
    check(!fin && mode == 4'd0, "R6 single pulse", int'(fin), 0);
    check(ok == exp_ok, "R7 rom_ok held", int'(ok), int'(exp_ok));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    for (int v = 0; v < 4; v++) run(VEC[v][9:2], VEC[v][1], VEC[v][0]);
    // reset in the middle of a sweep
    seed = 8'h00;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    check(mode == 4'd6, "R2 sweep in progress", int'(mode), 6);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid-sweep");
    @(negedge clk) rst_n = 1'b1;
    run(8'h00, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule